// File: doc/BRIEF.md
# Single-Bit Code Comparator and Fix Locator

This block settles the outcome of one 512-byte chunk protected by a 24-bit single-error-correcting code. It is given two codes. One is the code that was stored alongside the chunk and later read back. The other is the code computed afresh over the chunk as it was read.

Each code is split into two 12-bit halves and combined into two syndromes. From these the block sorts the chunk into one of four results:

- the chunk is clean;
- one data bit has flipped, and its location is given;
- one bit of the stored code itself has flipped;
- the damage cannot be repaired.

For a flipped data bit, the block reports the byte offset inside the chunk, the bit index and an 8-bit mask. The surrounding logic XORs that mask into the addressed byte of its buffer. The block never touches the buffer itself.

A pulse on `start` launches a comparison. The result is registered and appears on the next clock cycle, together with a one-cycle `done` pulse. It then stays on the outputs until the next start.

Top module: `sbecc_resolver`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status`, `byte_addr`, `bit_idx`, `bit_mask`, `fixed` and `done` are all zero.
- R2: The lower half of a code is bits [11:0], which are byte 0 and the low nibble of byte 1. The upper half is bits [23:12]. The odd syndrome is the XOR of the two lower halves, and the even syndrome is the XOR of the two upper halves.
- R3: When both syndromes are zero, `status` is 2'b00 (clean) and `fixed` is 0.
- R4: When the odd syndrome equals the 12-bit complement of the even syndrome, `status` is 2'b01 (data fix). In that case `byte_addr` is odd[11:3], `bit_idx` is odd[2:0] and `bit_mask` is 1 shifted left by `bit_idx`.
- R5: When neither R3 nor R4 applies and the OR of the two syndromes has exactly one bit set, `status` is 2'b10 (code fix). No data change is needed, but `fixed` is 1.
- R6: Every other syndrome pattern gives `status` 2'b11 (uncorrectable).
- R7: When `engine_fail` is high together with `start`, `status` is 2'b11 whatever the codes are.
- R8: The result appears on the clock cycle after `start` is sampled, with `done` high for exactly that one cycle. `fixed` is 1 exactly for statuses 2'b01 and 2'b10.
- R9: Without `start`, changes on `code_rd`, `code_calc` or `engine_fail` leave all outputs unchanged, and `done` stays low.
- R10: Whenever `status` is not 2'b01, `byte_addr`, `bit_idx` and `bit_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one comparison |
| engine_fail | input | 1 | The computed code is flagged unusable |
| code_rd | input | 24 | Code read back from the spare area |
| code_calc | input | 24 | Code computed over the chunk |
| status | output | 2 | 00 clean, 01 data fix, 10 code fix, 11 uncorrectable |
| byte_addr | output | 9 | Byte offset of the flipped data bit |
| bit_idx | output | 3 | Bit position of the flipped data bit |
| bit_mask | output | 8 | One-hot mask to XOR into the addressed byte |
| fixed | output | 1 | One correction was counted |
| done | output | 1 | Result valid pulse |

## Verification
The bench places flipped data bits at the extreme locations, byte 0 bit 0 and byte 511 bit 7. A design that swapped the halves or the syndrome fields would report the wrong location, or would not report a data fix at all.

Single flips in the stored code are applied in both halves. One further pattern has equal one-bit syndromes in both halves, which makes their OR one-hot. A comparator that counted bits per half instead of on the OR would misclassify these.

A failed-engine flag is combined with patterns that would otherwise be clean or fixable, to confirm the override. Further cases change the inputs without a start and issue back-to-back starts, to catch a design that is not truly registered or that stretches `done`.

// File: rtl/sbecc_resolver.sv
module sbecc_resolver #(
  parameter int CODE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              engine_fail,
  input  logic [CODE_W-1:0] code_rd,
  input  logic [CODE_W-1:0] code_calc,
  output logic [1:0]        status,
  output logic [CODE_W/2-4:0] byte_addr,
  output logic [2:0]        bit_idx,
  output logic [7:0]        bit_mask,
  output logic              fixed,
  output logic              done
);
  localparam int HW = CODE_W / 2;
  localparam int AW = HW - 3;
  localparam logic [1:0] ST_CLEAN = 2'b00;
  localparam logic [1:0] ST_DATA  = 2'b01;
  localparam logic [1:0] ST_CODE  = 2'b10;
  localparam logic [1:0] ST_BAD   = 2'b11;

  logic [HW-1:0] syn_odd, syn_even, syn_any;
  logic          hit_clean, hit_data, hit_code;
  logic [1:0]    st_next;

  assign syn_odd   = code_rd[HW-1:0]      ^ code_calc[HW-1:0];
  assign syn_even  = code_rd[CODE_W-1:HW] ^ code_calc[CODE_W-1:HW];
  assign syn_any   = syn_odd | syn_even;
  assign hit_clean = (syn_any == '0);
  assign hit_data  = (syn_odd == ~syn_even);
  assign hit_code  = !hit_clean && ((syn_any & (syn_any - 1'b1)) == '0);

  always_comb begin
    if (engine_fail)    st_next = ST_BAD;
    else if (hit_clean) st_next = ST_CLEAN;
    else if (hit_data)  st_next = ST_DATA;
    else if (hit_code)  st_next = ST_CODE;
    else                st_next = ST_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= ST_CLEAN;
      byte_addr <= '0;
      bit_idx   <= '0;
      bit_mask  <= '0;
      fixed     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        status <= st_next;
        fixed  <= (st_next == ST_DATA) || (st_next == ST_CODE);
        if (st_next == ST_DATA) begin
          byte_addr <= syn_odd[HW-1:3];
          bit_idx   <= syn_odd[2:0];
          bit_mask  <= 8'(1) << syn_odd[2:0];
        end else begin
          byte_addr <= '0;
          bit_idx   <= '0;
          bit_mask  <= '0;
        end
      end
    end
  end

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r8_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  a_r9_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(status) && $stable(byte_addr) && $stable(bit_mask));
  a_r10_quiet_location: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_DATA) |-> (byte_addr == '0 && bit_idx == '0 && bit_mask == '0));
  a_r4_mask_single: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_DATA) |-> $countones(bit_mask) == 1);
  a_r7_fail_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    (start && engine_fail) |=> status == ST_BAD && !fixed);
  a_r3_equal_codes_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !engine_fail && code_rd == code_calc) |=> status == ST_CLEAN);
endmodule

// File: tb/sim_sbecc_resolver.sv
module sim_sbecc_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 5000;
  localparam int NV = 10;
  // fields: fail[62] calc[61:38] diff[37:14] status[13:12] byte[11:3] bit[2:0]
  localparam logic [62:0] VEC [0:NV-1] = '{
    {1'b0, 24'h5A3C81, 24'h000000, 2'd0, 9'd0,   3'd0},  // R3 clean
    {1'b0, 24'h123456, 24'hFFF000, 2'd1, 9'd0,   3'd0},  // R4 byte 0 bit 0
    {1'b0, 24'hABCDEF, 24'h000FFF, 2'd1, 9'd511, 3'd7},  // R4 byte 511 bit 7
    {1'b0, 24'h00FF00, 24'hFD402B, 2'd1, 9'd5,   3'd3},  // R4 byte 5 bit 3
    {1'b0, 24'h777777, 24'h800000, 2'd2, 9'd0,   3'd0},  // R5 upper code bit
    {1'b0, 24'h0F0F0F, 24'h000400, 2'd2, 9'd0,   3'd0},  // R5 lower code bit
    {1'b0, 24'h0C0C0C, 24'h001001, 2'd2, 9'd0,   3'd0},  // R5 OR is one-hot
    {1'b0, 24'h314159, 24'h000003, 2'd3, 9'd0,   3'd0},  // R6 two bits
    {1'b1, 24'h271828, 24'h000000, 2'd3, 9'd0,   3'd0},  // R7 fail, clean codes
    {1'b1, 24'h161803, 24'hFD402B, 2'd3, 9'd0,   3'd0}   // R7 fail, data pattern
  };

  logic clk = 0, rst_n = 0, start = 0, engine_fail = 0;
  logic [23:0] code_rd = '0, code_calc = '0;
  logic [1:0] status;
  logic [8:0] byte_addr;
  logic [2:0] bit_idx;
  logic [7:0] bit_mask;
  logic fixed, done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbecc_resolver u0 (.clk(clk), .rst_n(rst_n), .start(start), .engine_fail(engine_fail),
    .code_rd(code_rd), .code_calc(code_calc), .status(status), .byte_addr(byte_addr),
    .bit_idx(bit_idx), .bit_mask(bit_mask), .fixed(fixed), .done(done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic f, input logic [23:0] rd, input logic [23:0] calc);
    @(negedge clk);
    engine_fail = f; code_rd = rd; code_calc = calc; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 0); chk("R1 byte", byte_addr, 0);
    chk("R1 mask", bit_mask, 0); chk("R1 done", done, 0); chk("R1 fixed", fixed, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {status, byte_addr, bit_idx, bit_mask, fixed, done}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] es;
      es = VEC[i][13:12];
      launch(VEC[i][62], VEC[i][61:38] ^ VEC[i][37:14], VEC[i][61:38]);
      chk("R8 done pulse", done, 1);
      chk("R2 R3 R5 R6 R7 status", status, es);
      chk("R4 R10 byte_addr", byte_addr, VEC[i][11:3]);
      chk("R4 R10 bit_idx", bit_idx, VEC[i][2:0]);
      chk("R4 R10 bit_mask", bit_mask, (es == 2'd1) ? (32'd1 << VEC[i][2:0]) : 0);
      chk("R8 fixed", fixed, (es == 2'd1 || es == 2'd2));
      @(negedge clk);
      chk("R8 done single cycle", done, 0);
    end

    // R9: inputs move with no start; outputs keep the byte-511 result
    launch(0, 24'hABCDEF ^ 24'h000FFF, 24'hABCDEF);
    engine_fail = 1; code_rd = 24'h000003; code_calc = 24'h0;
    repeat (3) @(negedge clk);
    chk("R9 status held", status, 1);
    chk("R9 byte held", byte_addr, 511);
    chk("R9 mask held", bit_mask, 8'h80);
    chk("R9 done low", done, 0);

    // R8: back-to-back starts, each result lands the next cycle
    @(negedge clk);
    engine_fail = 0; code_calc = 24'h0; code_rd = 24'h800000; start = 1;
    @(negedge clk);
    chk("R8 b2b first", status, 2); chk("R8 b2b done1", done, 1);
    code_rd = 24'hFFF000;
    @(negedge clk);
    start = 0;
    chk("R8 b2b second", status, 1); chk("R8 b2b done2", done, 1);
    @(negedge clk);
    chk("R8 b2b done off", done, 0);

    // R1: reset after a data-fix result clears everything
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid reset", {status, byte_addr, bit_idx, bit_mask, fixed, done}, 0);
    rst_n = 1;
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule